// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction per rising clock edge. It fetches a word from its own instruction store, decodes it, reads two operands from a 32-entry register file, runs them through an ALU, and then does three things together at the edge: it writes a register, writes a word of data memory, and updates the program counter. The supported instructions are seven register-to-register operations (add, sub, and, or, xor, nor, set-on-less-than), word load, word store, branch-if-equal and an absolute jump. The instruction store and the data store are separate word-indexed arrays inside the core.

Before the core runs, the instruction store is filled through a write port while reset is held. Once reset is released, execution starts at address 0. Every register write and every store is visible at the ports during the cycle before it takes effect, which lets an observer follow the architectural state one instruction at a time.

The main decoder reads only the opcode. It drives the destination select, operand select, load-result select, write enables, branch and jump controls, and a 2-bit ALU class. A second decode stage turns that class and the function code into a 4-bit ALU operation. Any encoding that is not recognised runs as a no-op.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0, and `wb_en` and `st_en` stay low during reset. After reset is released, a read of any register returns 0 until that register is written.
- R2: An instruction with opcode 0x00 and shamt (bits 10-6) equal to 0 writes rd (bits 15-11) with rs op rt, where rs is bits 25-21, rt is bits 20-16 and the function code is bits 5-0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor. Sums and differences wrap modulo 2^32.
- R3: Function code 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 0x23 (load) writes rt with the data word at byte address rs + sign-extended bits 15-0.
- R5: Opcode 0x2B (store) writes rt to the data word at byte address rs + sign-extended bits 15-0 and writes no register. `st_en` is high for exactly these instructions.
- R6: Opcode 0x04 (branch) sets the next PC to PC+4 + (sign-extended bits 15-0 × 4) when rs equals rt, and to PC+4 otherwise. It writes neither a register nor memory.
- R7: Opcode 0x02 (jump) sets the next PC to {bits 31-28 of PC+4, bits 25-0, 2'b00} and writes nothing.
- R8: Register 0 always reads as 0. A write that targets it is reported on the write-back port but leaves register 0 unchanged.
- R9: An opcode other than those listed above, or opcode 0x00 with an unlisted function code or a non-zero shamt, writes no register and no memory and advances the PC by 4.
- R10: Every instruction that is neither a taken branch nor a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IAW | Word index written in the instruction store |
| imem_wdata | input | 32 | Instruction word to store |
| pc | output | 32 | Byte address of the instruction now executing |
| wb_en | output | 1 | A register write happens at the next edge |
| wb_reg | output | 5 | Destination register selected (rd or rt) |
| wb_data | output | 32 | Value to be written to the register |
| st_en | output | 1 | A data store happens at the next edge |
| st_addr | output | 32 | Byte address computed for load and store |
| st_data | output | 32 | Word to be stored (rt value) |

## Verification
The assertions assume that the instruction store is written only while reset is held, so the word being executed never changes under the core. They also assume that loads and stores use word-aligned addresses, and that a load reads only words the program has already stored, since the data store has no reset. The stimulus loads the whole program during reset and uses only aligned offsets. Its first load reads an address that an earlier store has written. Its program stops in a branch that loops back to itself, so that a long run stays on known instructions.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // ALU operation code; bit 3 marks the subtracting operations
  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_XOR = 4'b0010,
    ALU_NOR = 4'b0011,
    ALU_ADD = 4'b0110,
    ALU_SUB = 4'b1110,
    ALU_SLT = 4'b1111
  } alu_op_e;

  // ALU class handed from the main decoder to the second decode stage
  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     opb_imm;
    logic     wb_load;
    logic     reg_write;
    logic     mem_read;
    logic     mem_write;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] pc4, input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc4, input logic [25:0] idx);
    return {pc4[31:28], idx, 2'b00};
  endfunction

  function automatic logic [31:0] alu_eval(input alu_op_e op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_XOR: return a ^ b;
      ALU_NOR: return ~(a | b);
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctl,
  output alu_op_e    alu_code
);
  alu_op_e fn_code;
  logic    fn_ok;
  logic    known_op;

  // function-code decode, independent of the opcode
  always_comb begin
    fn_ok   = (shamt == 5'd0);
    fn_code = ALU_ADD;
    case (funct)
      FN_ADD:  fn_code = ALU_ADD;
      FN_SUB:  fn_code = ALU_SUB;
      FN_AND:  fn_code = ALU_AND;
      FN_OR:   fn_code = ALU_OR;
      FN_XOR:  fn_code = ALU_XOR;
      FN_NOR:  fn_code = ALU_NOR;
      FN_SLT:  fn_code = ALU_SLT;
      default: fn_ok   = 1'b0;
    endcase
  end

  // main decode from the opcode
  always_comb begin
    ctl      = '0;
    known_op = 1'b1;
    case (opcode)
      OP_RTYPE: begin
        ctl.dst_rd    = 1'b1;
        ctl.reg_write = fn_ok;
        ctl.alu_cls   = CLS_FUNCT;
      end
      OP_LW: begin
        ctl.opb_imm   = 1'b1;
        ctl.wb_load   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.mem_read  = 1'b1;
      end
      OP_SW: begin
        ctl.opb_imm   = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch  = 1'b1;
        ctl.alu_cls = CLS_SUB;
      end
      OP_J: ctl.jump = 1'b1;
      default: known_op = 1'b0;
    endcase
  end

  always_comb begin
    case (ctl.alu_cls)
      CLS_SUB:   alu_code = ALU_SUB;
      CLS_FUNCT: alu_code = fn_code;
      default:   alu_code = ALU_ADD;
    endcase
  end

  // R5
  decode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.mem_write, ctl.reg_write, ctl.branch, ctl.jump}));

  // R9
  unknown_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (!known_op || (opcode == OP_RTYPE && !fn_ok)) |-> !(ctl.reg_write || ctl.mem_write || ctl.branch || ctl.jump));
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int NREG = 32,
  parameter  int W    = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R8
  r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((ra_a == '0) |-> (rd_a == '0)) and ((ra_b == '0) |-> (rd_b == '0)));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [IAW-1:0] imem_waddr,
  input  logic [31:0]    imem_wdata,
  output logic [31:0]    pc,
  output logic           wb_en,
  output logic [4:0]     wb_reg,
  output logic [31:0]    wb_data,
  output logic           st_en,
  output logic [31:0]    st_addr,
  output logic [31:0]    st_data
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] pc_q, pc4, pc_next, instr;
  logic [31:0] rs_val, rt_val, opb, alu_y, ld_data;
  logic        alu_zero, take_br;
  ctrl_t       ctl;
  alu_op_e     alu_code;

  // instruction store: loaded through the write port, read at the PC
  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  sc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (instr[31:26]),
    .funct    (instr[5:0]),
    .shamt    (instr[10:6]),
    .ctl      (ctl),
    .alu_code (alu_code)
  );

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_en),
    .waddr (wb_reg),
    .wdata (wb_data),
    .ra_a  (instr[25:21]),
    .ra_b  (instr[20:16]),
    .rd_a  (rs_val),
    .rd_b  (rt_val)
  );

  assign opb = ctl.opb_imm ? sext16(instr[15:0]) : rt_val;

  sc_alu #(.W(32)) u_alu (
    .op   (alu_code),
    .a    (rs_val),
    .b    (opb),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: word indexed by the byte address
  always_ff @(posedge clk) begin
    if (st_en) dmem[alu_y[DAW+1:2]] <= rt_val;
  end
  assign ld_data = ctl.mem_read ? dmem[alu_y[DAW+1:2]] : '0;

  // write-back and store events brought out
  assign wb_en   = ctl.reg_write & ~rst;
  assign wb_reg  = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctl.wb_load ? ld_data : alu_y;
  assign st_en   = ctl.mem_write & ~rst;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  // next-PC selection
  assign pc4     = pc_q + 32'd4;
  assign take_br = ctl.branch & alu_zero;
  always_comb begin
    if (ctl.jump)     pc_next = jump_target(pc4, instr[25:0]);
    else if (take_br) pc_next = branch_target(pc4, instr[15:0]);
    else              pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end
  assign pc = pc_q;

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

  // R10
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6
  br_eq_chk: assert property (@(posedge clk) disable iff (rst)
    take_br |-> (rs_val == rt_val));

  // R7
  jmp_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  // R5
  st_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] pc, wb_data, st_addr, st_data;
  logic [4:0]  wb_reg;
  logic        wb_en, st_en;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;  // 50 MHz

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pc(pc), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );

  // reference model state
  logic [31:0] prog [IW];
  logic [31:0] mregs [32];
  logic [31:0] mmem [DW];
  logic [31:0] mpc;
  string       pc_tag = "R1";

  function automatic logic [31:0] rop(int rs, int rt, int rd, int fn, int sh = 0);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iop(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mpc = 0;
    for (int i = 0; i < 32; i++) mregs[i] = 0;
  endtask

  // compare the ports against the model, then advance the model one instruction
  task automatic step();
    logic [31:0] ins, a, b, res, nxt, addr;
    int op, fn, rs, rt, rd, sh, simm;
    logic        e_wb, e_st;
    logic [4:0]  e_reg;
    string       tag;
    #1;
    ins  = prog[(mpc >> 2) % IW];
    op   = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
    rd   = int'(ins[15:11]); sh = int'(ins[10:6]);  fn = int'(ins[5:0]);
    simm = int'($signed(ins[15:0]));
    a = mregs[rs]; b = mregs[rt];
    e_wb = 0; e_st = 0; e_reg = 0; res = 0; addr = a + 32'(simm);
    nxt = mpc + 4; tag = "R9";
    if (op == 0 && sh == 0) begin
      e_wb = 1; e_reg = 5'(rd); tag = "R2";
      case (fn)
        32: res = a + b;
        34: res = a - b;
        36: res = a & b;
        37: res = a | b;
        38: res = a ^ b;
        39: res = ~(a | b);
        42: begin res = (int'(a) < int'(b)) ? 1 : 0; tag = "R3"; end
        default: begin e_wb = 0; tag = "R9"; end
      endcase
    end else if (op == 35) begin
      e_wb = 1; e_reg = 5'(rt); res = mmem[(addr >> 2) % DW]; tag = "R4";
    end else if (op == 43) begin
      e_st = 1; tag = "R5";
    end else if (op == 4) begin
      tag = "R6";
      if (a == b) nxt = mpc + 4 + 32'(simm * 4);
    end else if (op == 2) begin
      tag = "R7";
      nxt = {nxt[31:28], ins[25:0], 2'b00};
    end
    if (e_wb && e_reg == 0) tag = "R8";
    if (mpc == 0 && op == 0 && fn == 32) tag = "R1";

    chk(pc_tag, "pc", pc, mpc);
    chk(tag, "wb_en", 32'(wb_en), 32'(e_wb));
    if (e_wb) begin
      chk(tag, "wb_reg", 32'(wb_reg), 32'(e_reg));
      chk(tag, "wb_data", wb_data, res);
    end
    chk(tag, "st_en", 32'(st_en), 32'(e_st));
    if (e_st) begin
      chk(tag, "st_addr", st_addr, addr);
      chk(tag, "st_data", st_data, b);
    end

    if (e_wb && e_reg != 0) mregs[e_reg] = res;
    if (e_st) mmem[(addr >> 2) % DW] = b;
    pc_tag = (op == 4 || op == 2) ? tag : "R10";
    mpc = nxt;
    @(negedge clk);
  endtask

  task automatic reset_cycles(int n);
    rst = 1'b1;
    repeat (n) begin
      @(negedge clk); #1;
      model_reset();
      chk("R1", "pc in reset", pc, 32'd0);
      chk("R1", "wb_en in reset", 32'(wb_en), 32'd0);
      chk("R1", "st_en in reset", 32'(st_en), 32'd0);
    end
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'd0;
    prog[0]  = rop(16, 0, 17, 32);         // r17 = r16 (zero after reset)
    prog[1]  = rop(0, 0, 1, 39);           // nor -> all ones
    prog[2]  = rop(0, 1, 2, 34);           // 0 - (-1) = 1
    prog[3]  = rop(2, 2, 3, 32);
    prog[4]  = rop(3, 3, 4, 32);
    prog[5]  = rop(1, 4, 5, 38);
    prog[6]  = rop(5, 3, 6, 36);
    prog[7]  = rop(3, 2, 7, 37);
    prog[8]  = rop(1, 2, 8, 42);           // -1 < 1 signed
    prog[9]  = rop(2, 1, 9, 42);
    prog[10] = rop(2, 2, 0, 32);           // write to r0
    prog[11] = iop(43, 4, 7, 8);
    prog[12] = iop(43, 4, 1, -4);
    prog[13] = iop(35, 0, 10, 12);
    prog[14] = iop(35, 0, 11, 0);
    prog[15] = iop(4, 10, 7, 2);           // taken
    prog[16] = rop(2, 2, 12, 32);
    prog[17] = rop(2, 2, 13, 32);
    prog[18] = iop(4, 2, 3, 5);            // not taken
    prog[19] = iop(8, 2, 14, 7);           // unknown opcode
    prog[20] = rop(2, 2, 14, 32, 1);       // shamt non-zero
    prog[21] = rop(1, 0, 16, 32);
    prog[22] = {6'd2, 26'd25};             // jump
    prog[23] = rop(2, 2, 12, 32);
    prog[24] = rop(2, 2, 13, 32);
    prog[25] = iop(4, 0, 0, -1);           // self loop
    prog[26] = rop(0, 0, 18, 21);          // unlisted funct, reached by nothing

    // load while reset is held
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    reset_cycles(2);
    repeat (40) step();
    // second run: reset must clear r16 written by the first run
    reset_cycles(3);
    repeat (40) step();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule